// File: doc/BRIEF.md
# HALT-Driven Power Mode Controller

This block sits beside a small microcontroller core and turns a HALT strobe into a low-power mode. At the HALT it reads a handful of control bits: an idle-enable bit, a bit that keeps the system clock running while idle, and the enables of the watchdog and the low-voltage detector. From these it picks one of four low-power modes and latches that mode on the next clock edge. While a low-power mode is active, the block drives the clock-enable outputs for the system clock, the time-base clock and the sub clock domain.

On entry the block sends a one-cycle clear pulse to the watchdog. It sets the power-down status flag and clears the watchdog time-out flag. It also tells the watchdog counter whether it may keep counting. That depends on whether the watchdog is enabled and whether the clock the watchdog uses is still running in the chosen mode. A wake-up event brings the block back to normal operation with every clock enabled.

The oscillators, the watchdog counter and the CPU pipeline lie outside this block. The core treats any non-zero mode code as "stalled". Registers, data memory and port states therefore stay unchanged, because nothing in the core advances.

Top module: `pm_halt_ctrl`

## Requirements
- R1: After reset the mode code is NORMAL (0). All three clock enables are 1, and the power-down flag, the time-out flag, the watchdog clear output and the watchdog run output are all 0.
- R2: If the idle-enable bit is 0 and the watchdog or the detector is enabled, a HALT in NORMAL gives mode SLEEP1 (code 2) after one edge. In SLEEP1 the system and time-base clock enables are 0 and the sub clock enable is 1.
- R3: If the idle-enable bit is 0 and both the watchdog and the detector are disabled, a HALT in NORMAL gives mode SLEEP0 (code 1) after one edge. In SLEEP0 all three clock enables are 0.
- R4: If the idle-enable bit is 1 and the system-clock-on bit is 0, a HALT in NORMAL gives mode IDLE0 (code 3) after one edge. In IDLE0 the system clock enable is 0, and the time-base and sub clock enables are 1.
- R5: If the idle-enable bit is 1 and the system-clock-on bit is 1, a HALT in NORMAL gives mode IDLE1 (code 4) after one edge. In IDLE1 all three clock enables are 1.
- R6: The power-down flag reads 1 and the time-out flag reads 0 in the first cycle that shows the new low-power mode.
- R7: The watchdog clear output is 1 in the first cycle that shows the new low-power mode and 0 in the cycle after it.
- R8: The watchdog run output is 1 exactly when the watchdog is enabled and its selected clock is enabled. Source select 1 means the sub clock and 0 means the system clock. So in IDLE0 a watchdog on the system clock stops and one on the sub clock runs, and in IDLE1 it runs on either source.
- R9: A wake-up event in a low-power mode gives NORMAL after one edge, with all clock enables at 1. The power-down flag stays 1.
- R10: A HALT is ignored while a low-power mode is active, and a wake-up event is ignored in NORMAL.
- R11: The software clear input clears both flags on the next edge. If a mode entry happens on the same edge, the entry wins and the power-down flag reads 1.
- R12: A watchdog time-out input sets the time-out flag on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_i | input | 1 | One-cycle HALT strobe from the core |
| idle_en_i | input | 1 | 1 selects an idle mode, 0 a sleep mode |
| sysclk_on_i | input | 1 | Keep the system clock running while idle |
| wdt_en_i | input | 1 | Watchdog enabled |
| lvd_en_i | input | 1 | Low-voltage detector enabled |
| wdt_src_sub_i | input | 1 | Watchdog clock source: 1 sub clock, 0 system clock |
| wake_i | input | 1 | Wake-up event |
| wdt_tmo_i | input | 1 | Watchdog time-out event |
| sw_clr_i | input | 1 | Software clear of both status flags |
| sysclk_en_o | output | 1 | System clock enable |
| tbclk_en_o | output | 1 | Time-base clock enable |
| subclk_en_o | output | 1 | Sub clock enable |
| wdt_clr_o | output | 1 | One-cycle watchdog clear pulse |
| wdt_run_o | output | 1 | Watchdog counter may count |
| mode_o | output | MODE_W | Current mode code |
| pdf_o | output | 1 | Power-down flag |
| to_o | output | 1 | Watchdog time-out flag |

## Verification
The bench builds the block with its default parameters: MODE_W of 3, the detector counted in the mode choice (HAS_LVD of 1), and a direct wake path (WAKE_SYNC_STAGES of 0). This setup means every mode change appears exactly one edge after its cause. Each of the four HALT decodes can then be checked cycle by cycle, and so can the clear pulse's single-cycle width and the wake return. With the detector counted, the SLEEP1 case reached through the detector alone (watchdog off) can be told apart from SLEEP0.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [2:0] {
      PM_NORMAL = 3'd0,
      PM_SLEEP0 = 3'd1,
      PM_SLEEP1 = 3'd2,
      PM_IDLE0  = 3'd3,
      PM_IDLE1  = 3'd4
   } pm_mode_e;

   localparam int unsigned PM_CODE_W = 3;

   typedef struct packed {
      logic sys;
      logic tb;
      logic sub;
   } pm_clk_en_t;

   function automatic pm_clk_en_t pm_clocks_for(input pm_mode_e m);
      pm_clk_en_t c;
      unique case (m)
         PM_SLEEP0: c = '{sys: 1'b0, tb: 1'b0, sub: 1'b0};
         PM_SLEEP1: c = '{sys: 1'b0, tb: 1'b0, sub: 1'b1};
         PM_IDLE0:  c = '{sys: 1'b0, tb: 1'b1, sub: 1'b1};
         PM_IDLE1:  c = '{sys: 1'b1, tb: 1'b1, sub: 1'b1};
         default:   c = '{sys: 1'b1, tb: 1'b1, sub: 1'b1};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pm_mode_decode.sv
module pm_mode_decode
   import pmc_pkg::*;
#(
   parameter bit HAS_LVD = 1'b1
) (
   input  logic     idle_en_i,
   input  logic     sysclk_on_i,
   input  logic     wdt_en_i,
   input  logic     lvd_en_i,
   output pm_mode_e target_o
);

   logic keep_sub;

   generate
      if (HAS_LVD) begin : g_with_lvd
         assign keep_sub = wdt_en_i | lvd_en_i;
      end else begin : g_no_lvd
         logic unused_lvd;
         assign unused_lvd = lvd_en_i;
         assign keep_sub   = wdt_en_i;
      end
   endgenerate

   always_comb begin
      if (idle_en_i) begin
         target_o = sysclk_on_i ? PM_IDLE1 : PM_IDLE0;
      end else begin
         target_o = keep_sub ? PM_SLEEP1 : PM_SLEEP0;
      end
   end

endmodule

// File: rtl/pm_wake_sync.sv
module pm_wake_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_i,
   output logic wake_o
);

   generate
      if (STAGES == 0) begin : g_direct
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign wake_o     = wake_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else if (STAGES == 1) begin
               chain_q <= wake_i;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], wake_i};
            end
         end
         assign wake_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pm_clock_ctrl.sv
module pm_clock_ctrl
   import pmc_pkg::*;
(
   input  pm_mode_e mode_i,
   input  logic     wdt_en_i,
   input  logic     wdt_src_sub_i,
   output logic     sysclk_en_o,
   output logic     tbclk_en_o,
   output logic     subclk_en_o,
   output logic     wdt_run_o
);

   pm_clk_en_t en;
   logic       src_running;

   always_comb begin
      en          = pm_clocks_for(mode_i);
      src_running = wdt_src_sub_i ? en.sub : en.sys;
   end

   assign sysclk_en_o = en.sys;
   assign tbclk_en_o  = en.tb;
   assign subclk_en_o = en.sub;
   assign wdt_run_o   = wdt_en_i & src_running;

   always_comb begin
      // R2/R3: only NORMAL and IDLE1 may drive the system clock
      if (sysclk_en_o) begin
         AST_SYSCLK_MODES: assert (mode_i == PM_NORMAL || mode_i == PM_IDLE1); // R2
      end
      // R3: in SLEEP0 the watchdog can never count
      if (mode_i == PM_SLEEP0) begin
         AST_SLEEP0_NO_RUN: assert (!wdt_run_o); // R3
      end
   end

endmodule

// File: rtl/pm_status_flags.sv
module pm_status_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_i,
   input  logic sw_clr_i,
   input  logic tmo_i,
   output logic pdf_o,
   output logic to_o
);

   logic pdf_q, to_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pdf_q <= 1'b0;
         to_q  <= 1'b0;
      end else begin
         if (enter_i) begin
            pdf_q <= 1'b1;
         end else if (sw_clr_i) begin
            pdf_q <= 1'b0;
         end
         if (enter_i || sw_clr_i) begin
            to_q <= 1'b0;
         end else if (tmo_i) begin
            to_q <= 1'b1;
         end
      end
   end

   assign pdf_o = pdf_q;
   assign to_o  = to_q;

   AST_PDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pdf_q && !sw_clr_i) |=> pdf_q); // R9
   AST_TO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_i && !enter_i && !sw_clr_i) |=> to_q); // R12
   AST_CLR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr_i && !enter_i) |=> (!pdf_q && !to_q)); // R11

endmodule

// File: rtl/pm_halt_ctrl.sv
module pm_halt_ctrl
   import pmc_pkg::*;
#(
   parameter int unsigned MODE_W           = 3,
   parameter bit          HAS_LVD          = 1'b1,
   parameter int unsigned WAKE_SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_i,
   input  logic              idle_en_i,
   input  logic              sysclk_on_i,
   input  logic              wdt_en_i,
   input  logic              lvd_en_i,
   input  logic              wdt_src_sub_i,
   input  logic              wake_i,
   input  logic              wdt_tmo_i,
   input  logic              sw_clr_i,
   output logic              sysclk_en_o,
   output logic              tbclk_en_o,
   output logic              subclk_en_o,
   output logic              wdt_clr_o,
   output logic              wdt_run_o,
   output logic [MODE_W-1:0] mode_o,
   output logic              pdf_o,
   output logic              to_o
);

   localparam int unsigned PAD_W = (MODE_W > PM_CODE_W) ? MODE_W - PM_CODE_W : 1;

   generate
      if (MODE_W < PM_CODE_W) begin : g_bad_mode_w
         $error("pm_halt_ctrl: MODE_W must be at least 3");
      end
      if (WAKE_SYNC_STAGES > 4) begin : g_bad_sync
         $error("pm_halt_ctrl: WAKE_SYNC_STAGES must not exceed 4");
      end
   endgenerate

   pm_mode_e mode_q, target;
   logic     clr_q, wake_s, enter;

   pm_mode_decode #(.HAS_LVD(HAS_LVD)) u_decode (
      .idle_en_i  (idle_en_i),
      .sysclk_on_i(sysclk_on_i),
      .wdt_en_i   (wdt_en_i),
      .lvd_en_i   (lvd_en_i),
      .target_o   (target)
   );

   pm_wake_sync #(.STAGES(WAKE_SYNC_STAGES)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .wake_i(wake_i),
      .wake_o(wake_s)
   );

   assign enter = halt_i && (mode_q == PM_NORMAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= PM_NORMAL;
         clr_q  <= 1'b0;
      end else begin
         clr_q <= enter;
         if (enter) begin
            mode_q <= target;
         end else if (wake_s && mode_q != PM_NORMAL) begin
            mode_q <= PM_NORMAL;
         end
      end
   end

   pm_clock_ctrl u_clk (
      .mode_i       (mode_q),
      .wdt_en_i     (wdt_en_i),
      .wdt_src_sub_i(wdt_src_sub_i),
      .sysclk_en_o  (sysclk_en_o),
      .tbclk_en_o   (tbclk_en_o),
      .subclk_en_o  (subclk_en_o),
      .wdt_run_o    (wdt_run_o)
   );

   pm_status_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .enter_i (enter),
      .sw_clr_i(sw_clr_i),
      .tmo_i   (wdt_tmo_i),
      .pdf_o   (pdf_o),
      .to_o    (to_o)
   );

   generate
      if (MODE_W > PM_CODE_W) begin : g_pad
         logic [PAD_W-1:0] pad;
         assign pad    = '0;
         assign mode_o = {pad, mode_q};
      end else begin : g_exact
         assign mode_o = mode_q;
      end
   endgenerate

   assign wdt_clr_o = clr_q;

   AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |=> !clr_q); // R7
   AST_CLR_WITH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |-> (mode_q != PM_NORMAL && pdf_o && !to_o)); // R6
   AST_HALT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != PM_NORMAL && !wake_s) |=> $stable(mode_q)); // R10
   AST_WAKE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != PM_NORMAL && wake_s) |=> (mode_q == PM_NORMAL)); // R9
   AST_ENTRY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> (mode_q != PM_NORMAL && clr_q)); // R7

endmodule

// File: tb/pm_halt_ctrl_tb.sv
`timescale 1ns/1ps
module pm_halt_ctrl_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt_i = 0, idle_en_i = 0, sysclk_on_i = 0, wdt_en_i = 0, lvd_en_i = 0;
   logic wdt_src_sub_i = 0, wake_i = 0, wdt_tmo_i = 0, sw_clr_i = 0;
   logic sysclk_en_o, tbclk_en_o, subclk_en_o, wdt_clr_o, wdt_run_o, pdf_o, to_o;
   logic [2:0] mode_o;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   pm_halt_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .idle_en_i(idle_en_i),
      .sysclk_on_i(sysclk_on_i), .wdt_en_i(wdt_en_i), .lvd_en_i(lvd_en_i),
      .wdt_src_sub_i(wdt_src_sub_i), .wake_i(wake_i), .wdt_tmo_i(wdt_tmo_i),
      .sw_clr_i(sw_clr_i), .sysclk_en_o(sysclk_en_o), .tbclk_en_o(tbclk_en_o),
      .subclk_en_o(subclk_en_o), .wdt_clr_o(wdt_clr_o), .wdt_run_o(wdt_run_o),
      .mode_o(mode_o), .pdf_o(pdf_o), .to_o(to_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_clocks(input string req, input int s, input int t, input int u);
      chk(req, "sysclk_en", sysclk_en_o, s);
      chk(req, "tbclk_en", tbclk_en_o, t);
      chk(req, "subclk_en", subclk_en_o, u);
   endtask

   // Issue a HALT in NORMAL; returns sampled in the cycle the mode appears.
   task automatic do_halt(input logic idle, input logic son, input logic wen, input logic len);
      @(negedge clk);
      idle_en_i = idle; sysclk_on_i = son; wdt_en_i = wen; lvd_en_i = len;
      halt_i = 1'b1;
      @(negedge clk);
      halt_i = 1'b0;
   endtask

   task automatic do_wake();
      @(negedge clk);
      wake_i = 1'b1;
      @(negedge clk);
      wake_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "mode", mode_o, 0);
      chk_clocks("R1", 1, 1, 1);
      chk("R1", "pdf", pdf_o, 0);
      chk("R1", "to", to_o, 0);
      chk("R1", "wdt_clr", wdt_clr_o, 0);
      chk("R1", "wdt_run", wdt_run_o, 0);
   endtask

   task automatic t_sleep1_wdt();
      wdt_src_sub_i = 1'b1;
      do_halt(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R2", "mode", mode_o, 2);
      chk_clocks("R2", 0, 0, 1);
      chk("R6", "pdf", pdf_o, 1);
      chk("R6", "to", to_o, 0);
      chk("R7", "wdt_clr first cycle", wdt_clr_o, 1);
      chk("R8", "wdt_run sleep1 sub", wdt_run_o, 1);
      @(negedge clk);
      chk("R7", "wdt_clr second cycle", wdt_clr_o, 0);
      do_wake();
      chk("R9", "mode after wake", mode_o, 0);
      chk_clocks("R9", 1, 1, 1);
      chk("R9", "pdf stays", pdf_o, 1);
   endtask

   task automatic t_sleep1_lvd();
      do_halt(1'b0, 1'b1, 1'b0, 1'b1);
      chk("R2", "mode via detector", mode_o, 2);
      chk("R8", "wdt_run disabled", wdt_run_o, 0);
      do_wake();
   endtask

   task automatic t_sleep0();
      do_halt(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R3", "mode", mode_o, 1);
      chk_clocks("R3", 0, 0, 0);
      do_wake();
   endtask

   task automatic t_idle0();
      wdt_src_sub_i = 1'b0;
      do_halt(1'b1, 1'b0, 1'b1, 1'b0);
      chk("R4", "mode", mode_o, 3);
      chk_clocks("R4", 0, 1, 1);
      chk("R8", "wdt_run idle0 sys src", wdt_run_o, 0);
      @(negedge clk);
      wdt_src_sub_i = 1'b1;
      #0.5;
      chk("R8", "wdt_run idle0 sub src", wdt_run_o, 1);
      // HALT while in low-power mode must not change mode
      @(negedge clk);
      idle_en_i = 1'b1; sysclk_on_i = 1'b1; halt_i = 1'b1;
      @(negedge clk);
      halt_i = 1'b0;
      chk("R10", "halt ignored", mode_o, 3);
      chk("R10", "no clr pulse", wdt_clr_o, 0);
      do_wake();
   endtask

   task automatic t_idle1();
      wdt_src_sub_i = 1'b0;
      do_halt(1'b1, 1'b1, 1'b1, 1'b0);
      chk("R5", "mode", mode_o, 4);
      chk_clocks("R5", 1, 1, 1);
      chk("R8", "wdt_run idle1 sys src", wdt_run_o, 1);
      do_wake();
      // wake in NORMAL: nothing changes, clear pulse absent
      do_wake();
      chk("R10", "wake ignored in normal", mode_o, 0);
      chk("R10", "wdt_clr", wdt_clr_o, 0);
   endtask

   task automatic t_flags();
      @(negedge clk);
      wdt_tmo_i = 1'b1;
      @(negedge clk);
      wdt_tmo_i = 1'b0;
      chk("R12", "to set", to_o, 1);
      sw_clr_i = 1'b1;
      @(negedge clk);
      sw_clr_i = 1'b0;
      chk("R11", "pdf cleared", pdf_o, 0);
      chk("R11", "to cleared", to_o, 0);
      // entry and software clear together: entry wins
      @(negedge clk);
      sw_clr_i = 1'b1; idle_en_i = 1'b1; sysclk_on_i = 1'b0; halt_i = 1'b1;
      @(negedge clk);
      sw_clr_i = 1'b0; halt_i = 1'b0;
      chk("R11", "pdf with entry", pdf_o, 1);
      chk("R11", "mode with entry", mode_o, 3);
      do_wake();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sleep1_wdt();
      t_sleep1_lvd();
      t_sleep0();
      t_idle0();
      t_idle1();
      t_flags();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule